// File: doc/BRIEF.md
# Sequenced ADC Scan Controller

This block runs an external analog-to-digital converter that sits behind an analog input multiplexer. Software fills a small sequence table. Each table word names an input channel, an oversampling exponent, whether the step must wait for a switching-edge trigger, which trigger to use, and whether the word ends the list. After a start pulse the controller walks the table in order. For each step it steers the multiplexer and pulses convert-start, then waits for the converter's done strobe. When the step asks for it, the convert-start pulse is held back until the chosen trigger rises.

Each step takes 2^exp conversions. The controller adds them up, shifts the sum right by exp, and writes the average into a result RAM at the slot of the step's channel. Several read ports give control-loop consumers and software access to that RAM at any time, with one cycle of latency. In continuous mode the scan wraps from the last entry back to entry 0. In single-shot mode it stops there, goes idle and raises a done flag that holds until the next start.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A sequence-table word is written through `tbl_we_i`/`tbl_addr_i`/`tbl_wdata_i`. Its bits are: [3:0] channel, [5:4] oversampling exponent e, [6] wait-for-trigger, [7] end-of-list, [8] trigger index. A word takes effect the next time its entry is used.
- R2: While scanning, `mux_sel_o` carries the channel of the current entry. Entries are used in order starting at entry 0 after each start.
- R3: `conv_start_o` is high for exactly one cycle per conversion. After it, no further pulse occurs until `adc_done_i` has been seen.
- R4: For each entry, 2^e conversions are summed. On the cycle of the last `adc_done_i`, the sum shifted right by e (12 bits) is written to the result slot named by the entry's channel.
- R5: When an entry's wait bit is set, `conv_start_o` is asserted only in the cycle after one in which the selected trigger input went from 0 to 1 while the step was waiting. A trigger that is already high, or that rises outside the waiting window, does not start a conversion.
- R6: After an entry with end-of-list set, or after entry 15, the next entry is entry 0 in continuous mode.
- R7: In single-shot mode (`single_i` captured at start), the controller goes idle after the last entry's result is written. `busy_o` drops and `done_o` rises in the same cycle. `done_o` stays high until a start is accepted.
- R8: `stop_i` puts the controller into idle in the next cycle. A conversion finishing in the stop cycle writes nothing, and `done_o` does not change.
- R9: Each read port returns the slot at `rd_addr_i` one cycle later. When a write to the same slot happens in that cycle, the port returns the value the slot held before the write.
- R10: After reset the controller is idle, `done_o` is 0, `conv_start_o` is 0, and every result slot reads 0.
- R11: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Sequence-table write strobe |
| tbl_addr_i | input | 4 | Sequence-table entry index |
| tbl_wdata_i | input | 9 | Sequence-table word (R1 layout) |
| start_i | input | 1 | Start a scan from entry 0 when idle |
| single_i | input | 1 | Single-shot mode, sampled at start |
| stop_i | input | 1 | Abort the scan |
| trig_i | input | 2 | Switching-edge trigger inputs |
| mux_sel_o | output | 4 | Analog multiplexer channel select |
| conv_start_o | output | 1 | Convert-start pulse to the ADC |
| adc_done_i | input | 1 | Conversion complete strobe |
| adc_data_i | input | 12 | Conversion result, valid with done |
| rd_addr_i | input | 2x4 | Read-port slot addresses |
| rd_data_o | output | 2x12 | Read-port data, one cycle after address |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Single-shot scan finished |

## Verification
Every output is registered or decoded from registered state, so the response to an input sampled at one rising edge shows up in the following cycle. A step with no trigger gives `conv_start_o` one cycle after the step begins. A triggered step gives it the cycle after the trigger edge. A result write lands at the edge where the final done strobe is sampled, and the read port shows it one cycle after that. The bench runs a behavioural model on the same rising edges from the same pin values. It compares every output to the model on the following falling edge, which lines up every one-cycle delay listed above. The ADC responder in the bench uses latencies of 1 to 3 cycles, and the trigger pulses are free-running. Together they place done strobes, trigger edges, stops and same-slot reads at varied offsets.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CH_W   = 4;
  localparam int OS_W   = 2;
  localparam int N_TRIG = 2;
  localparam int TSEL_W = $clog2(N_TRIG);

  typedef struct packed {
    logic [TSEL_W-1:0] trig_idx;
    logic              eol;
    logic              wait_trig;
    logic [OS_W-1:0]   os_exp;
    logic [CH_W-1:0]   ch;
  } seq_entry_t;

  localparam int ENTRY_W = $bits(seq_entry_t);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ARM  = 2'd1,
    S_CONV = 2'd2,
    S_WAIT = 2'd3
  } scan_state_e;
endpackage

// File: rtl/adc_seq_table.sv
module adc_seq_table
  import adc_scan_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(N_ENT)-1:0] waddr_i,
  input  logic [ENTRY_W-1:0]       wdata_i,
  input  logic [$clog2(N_ENT)-1:0] ridx_i,
  output seq_entry_t               entry_o
);
  seq_entry_t tbl_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) tbl_q[i] <= '0;
    end else if (we_i && (int'(waddr_i) < N_ENT)) begin
      tbl_q[waddr_i] <= seq_entry_t'(wdata_i);
    end
  end

  assign entry_o = tbl_q[ridx_i];
endmodule

// File: rtl/adc_result_ram.sv
module adc_result_ram
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int N_RD   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [CH_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [N_RD-1:0][CH_W-1:0]  rd_addr_i,
  output logic [N_RD-1:0][DATA_W-1:0] rd_data_o
);
  localparam int N_SLOT = 1 << CH_W;

  logic [DATA_W-1:0] mem_q [N_SLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOT; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    // registered read sees the pre-write contents on a same-slot collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_data_o[g] <= '0;
      else         rd_data_o[g] <= mem_q[rd_addr_i[g]];
    end

    a_r9_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i ##1 $stable(rd_addr_i[g])) |=> $stable(rd_data_o[g]));
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int DATA_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     single_i,
  input  logic                     stop_i,
  input  logic [N_TRIG-1:0]        trig_i,
  input  seq_entry_t               cur_i,
  output logic [$clog2(N_ENT)-1:0] idx_o,
  input  logic                     adc_done_i,
  input  logic [DATA_W-1:0]        adc_data_i,
  output logic                     conv_start_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     wr_en_o,
  output logic [CH_W-1:0]          wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int CNT_W = (1 << OS_W) - 1;
  localparam int ACC_W = DATA_W + CNT_W;

  scan_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  acc_q;
  logic              single_q;
  logic              done_q;
  logic [N_TRIG-1:0] trig_q;

  logic [CNT_W-1:0]  cnt_last;
  logic              last_sample;
  logic              last_entry;
  logic              trig_edge;
  logic              step_go;
  logic [ACC_W-1:0]  sum;

  assign cnt_last    = (CNT_W'(1) << cur_i.os_exp) - CNT_W'(1);
  assign last_sample = (cnt_q == cnt_last);
  assign last_entry  = cur_i.eol || (idx_q == IDX_W'(N_ENT - 1));
  assign trig_edge   = trig_i[cur_i.trig_idx] & ~trig_q[cur_i.trig_idx];
  assign step_go     = !cur_i.wait_trig || trig_edge;
  assign sum         = acc_q + ACC_W'(adc_data_i);

  assign wr_en_o      = (state_q == S_WAIT) && adc_done_i && last_sample && !stop_i;
  assign wr_addr_o    = cur_i.ch;
  assign wr_data_o    = DATA_W'(sum >> cur_i.os_exp);
  assign conv_start_o = (state_q == S_CONV);
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign idx_o        = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
      single_q <= 1'b0;
      done_q   <= 1'b0;
      trig_q   <= '0;
    end else begin
      trig_q <= trig_i;
      if (stop_i) begin
        state_q <= S_IDLE;
        idx_q   <= '0;
        cnt_q   <= '0;
        acc_q   <= '0;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (start_i) begin
              state_q  <= S_ARM;
              idx_q    <= '0;
              cnt_q    <= '0;
              acc_q    <= '0;
              single_q <= single_i;
              done_q   <= 1'b0;
            end
          end
          S_ARM:  if (step_go) state_q <= S_CONV;
          S_CONV: state_q <= S_WAIT;
          S_WAIT: begin
            if (adc_done_i) begin
              state_q <= S_ARM;
              if (last_sample) begin
                cnt_q <= '0;
                acc_q <= '0;
                if (last_entry) begin
                  idx_q <= '0;
                  if (single_q) begin
                    state_q <= S_IDLE;
                    done_q  <= 1'b1;
                  end
                end else begin
                  idx_q <= idx_q + IDX_W'(1);
                end
              end else begin
                acc_q <= sum;
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  a_r3_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  a_r3_hold_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !conv_start_o && state_q != S_ARM && !adc_done_i) |=> !conv_start_o);

  a_r5_gate_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ARM && cur_i.wait_trig && !(trig_i[cur_i.trig_idx] && !trig_q[cur_i.trig_idx]))
      |=> !conv_start_o);

  a_r8_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_o && !wr_en_o && $stable(done_o)));

  a_r7_done_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !stop_i && !done_o) |=> !$rose(done_o) || !busy_o);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int DATA_W = 12,
  parameter int N_RD   = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tbl_we_i,
  input  logic [$clog2(N_ENT)-1:0]    tbl_addr_i,
  input  logic [ENTRY_W-1:0]          tbl_wdata_i,
  input  logic                        start_i,
  input  logic                        single_i,
  input  logic                        stop_i,
  input  logic [N_TRIG-1:0]           trig_i,
  output logic [CH_W-1:0]             mux_sel_o,
  output logic                        conv_start_o,
  input  logic                        adc_done_i,
  input  logic [DATA_W-1:0]           adc_data_i,
  input  logic [N_RD-1:0][CH_W-1:0]   rd_addr_i,
  output logic [N_RD-1:0][DATA_W-1:0] rd_data_o,
  output logic                        busy_o,
  output logic                        done_o
);
  localparam int IDX_W = $clog2(N_ENT);

  seq_entry_t        cur;
  logic [IDX_W-1:0]  idx;
  logic              wr_en;
  logic [CH_W-1:0]   wr_addr;
  logic [DATA_W-1:0] wr_data;

  adc_seq_table #(.N_ENT(N_ENT)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_wdata_i),
    .ridx_i  (idx),
    .entry_o (cur)
  );

  adc_scan_fsm #(.N_ENT(N_ENT), .DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .single_i     (single_i),
    .stop_i       (stop_i),
    .trig_i       (trig_i),
    .cur_i        (cur),
    .idx_o        (idx),
    .adc_done_i   (adc_done_i),
    .adc_data_i   (adc_data_i),
    .conv_start_o (conv_start_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data)
  );

  adc_result_ram #(.DATA_W(DATA_W), .N_RD(N_RD)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign mux_sel_o = cur.ch;
endmodule

// File: tb/tb_adc_scan_ctrl.sv
`timescale 1ns/1ps
module tb_adc_scan_ctrl;
  localparam int N_ENT  = 16;
  localparam int DATA_W = 12;
  localparam int N_RD   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [8:0] tbl_wdata = '0;
  logic start = 1'b0, single = 1'b0, stop = 1'b0;
  logic [1:0] trig = '0;
  logic [3:0] mux_sel;
  logic conv_start;
  logic adc_done = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic [N_RD-1:0][3:0] rd_addr = '0;
  logic [N_RD-1:0][DATA_W-1:0] rd_data;
  logic busy, done;

  always #10 clk = ~clk;

  adc_scan_ctrl #(.N_ENT(N_ENT), .DATA_W(DATA_W), .N_RD(N_RD)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata),
    .start_i(start), .single_i(single), .stop_i(stop), .trig_i(trig),
    .mux_sel_o(mux_sel), .conv_start_o(conv_start),
    .adc_done_i(adc_done), .adc_data_i(adc_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 waiting to start, 2 converting pulse, 3 awaiting done
  logic [8:0] m_tbl [16];
  int m_mem [16];
  int m_rd [N_RD];
  int m_state, m_idx, m_cnt, m_acc, m_single, m_done;
  logic [1:0] m_tprev;
  int e_word, e_ch, e_os, e_n, m_sum;
  int rd_next [N_RD];
  bit m_go;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_tbl[i] = '0; m_mem[i] = 0; end
      for (int p = 0; p < N_RD; p++) m_rd[p] = 0;
      m_state = 0; m_idx = 0; m_cnt = 0; m_acc = 0; m_single = 0; m_done = 0;
      m_tprev = '0;
    end else begin
      e_word = int'(m_tbl[m_idx]);
      e_ch = e_word & 15;
      e_os = (e_word >> 4) & 3;
      e_n = 1 << e_os;
      for (int p = 0; p < N_RD; p++) rd_next[p] = m_mem[rd_addr[p]];
      if (stop) begin
        m_state = 0; m_idx = 0; m_cnt = 0; m_acc = 0;
      end else if (m_state == 0) begin
        if (start) begin
          m_state = 1; m_idx = 0; m_cnt = 0; m_acc = 0; m_single = int'(single); m_done = 0;
        end
      end else if (m_state == 1) begin
        m_go = ((e_word >> 6) & 1) == 0;
        if (((e_word >> 6) & 1) == 1) m_go = trig[(e_word >> 8) & 1] && !m_tprev[(e_word >> 8) & 1];
        if (m_go) m_state = 2;
      end else if (m_state == 2) begin
        m_state = 3;
      end else if (adc_done) begin
        m_sum = m_acc + int'(adc_data);
        m_state = 1;
        if (m_cnt == e_n - 1) begin
          m_mem[e_ch] = m_sum >> e_os;
          m_cnt = 0; m_acc = 0;
          if (((e_word >> 7) & 1) == 1 || m_idx == 15) begin
            m_idx = 0;
            if (m_single != 0) begin m_state = 0; m_done = 1; end
          end else m_idx = m_idx + 1;
        end else begin
          m_acc = m_sum; m_cnt = m_cnt + 1;
        end
      end
      for (int p = 0; p < N_RD; p++) m_rd[p] = rd_next[p];
      m_tprev = trig;
      if (tbl_we) m_tbl[tbl_addr] = tbl_wdata;
    end
  end

  // ADC responder, trigger generator, read sweep, and per-cycle comparison
  int pend = 0, k = 0, cyc = 0, conv_ch = 0;
  bit trig_on = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 R2 R6 mux_sel", int'(mux_sel), int'(m_tbl[m_idx][3:0]));
      chk("R3 R5 conv_start", int'(conv_start), int'(m_state == 2));
      chk("R7 R8 R11 busy", int'(busy), int'(m_state != 0));
      chk("R7 done", int'(done), m_done);
      for (int p = 0; p < N_RD; p++) chk("R4 R9 rd_data", int'(rd_data[p]), m_rd[p]);
    end
    cyc++;
    adc_done <= 1'b0;
    if (conv_start) begin
      pend = 1 + (k % 3);
      conv_ch = int'(mux_sel);
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        adc_done <= 1'b1;
        adc_data <= DATA_W'((conv_ch * 263 + k * 151 + 40) % 4096);
        k++;
      end
    end
    trig[0] <= trig_on && (cyc % 23 == 0);
    trig[1] <= trig_on && (cyc % 37 < 3);
    rd_addr[0] <= rd_addr[0] + 4'd1;
  end

  task automatic wr_tbl(input int a, input int w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(a); tbl_wdata = 9'(w);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic pulse_start(input bit ss);
    @(negedge clk);
    start = 1'b1; single = ss;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected scan completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy after reset", int'(busy), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 conv_start after reset", int'(conv_start), 0);
    chk("R10 result slot after reset", int'(rd_data[1]), 0);

    // single-shot list: plain, 4x average, trig0-gated 2x, trig1-gated 8x end
    wr_tbl(0, 9'h003);
    wr_tbl(1, 9'h027);
    wr_tbl(2, 9'h051);
    wr_tbl(3, 9'h1FC);
    trig_on = 1'b1;
    pulse_start(1'b1);
    repeat (20) @(negedge clk);
    pulse_start(1'b0);      // R11 ignored while busy
    wait_idle(3000);
    chk("R7 single-shot finished", int'(done), 1);
    foreach (rd_addr[p]) ;
    rd_addr[1] = 4'd12; repeat (2) @(negedge clk);
    rd_addr[1] = 4'd7;  repeat (2) @(negedge clk);
    rd_addr[1] = 4'd1;  repeat (2) @(negedge clk);
    rd_addr[1] = 4'd3;  repeat (2) @(negedge clk);

    // rerun single-shot; done clears on start
    pulse_start(1'b1);
    chk("R7 done cleared on start", int'(done), 0);
    wait_idle(3000);

    // continuous over all 16 entries without end-of-list: wrap at entry 15 (R6)
    for (int i = 0; i < 16; i++)
      wr_tbl(i, ((i & 1) << 8) | (((i % 5) == 0 ? 1 : 0) << 6) | ((i % 2) << 4) | (15 - i));
    pulse_start(1'b0);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      rd_addr[1] = mux_sel;  // chase the slot being written (R9)
    end
    pulse_stop();
    chk("R8 idle after stop", int'(busy), 0);
    repeat (10) @(negedge clk);

    // continuous with early end-of-list at entry 2, then stop mid-scan
    wr_tbl(2, 9'h085);
    pulse_start(1'b0);
    repeat (400) @(negedge clk);
    pulse_stop();
    repeat (5) @(negedge clk);
    pulse_start(1'b0);
    repeat (37) @(negedge clk);
    pulse_stop();
    repeat (10) @(negedge clk);

    summary();
    $finish;
  end
endmodule